// File: doc/BRIEF.md
# Three-Wire Skew Register Loader

This block is a write-only serial slave that sets three per-channel skew codes and a comparator slice level from a narrow three-wire link. The master pulls a frame-select line low, then presents data that the block captures on every falling edge of the serial clock. Every eight captured bits form one command word. Its top bit must be zero, the next two bits pick a target, and the low five bits carry the value. Words can follow each other without gaps, so one frame of 24 clocks can load all three channels.

The three serial pins are not related to the system clock. Each one passes through a two-stage synchronizer, and serial clock edges are found by comparing samples in the system domain. The register contents are always present as parallel outputs. Two single-cycle strobes mark activity. `word_done` fires once for each completed word. `cal_req` fires when the frame-select line returns high after a frame that changed at least one register, so downstream logic can start an offset calibration. There is no stream data path and no back-pressure: both strobes are plain pulses that cannot be stalled, and a consumer must sample them on the cycle they occur.

Top module: `skew_ser_cfg`

## Requirements
- R1: After reset the three channel codes and the slice level are zero, and neither strobe is asserted.
- R2: While `ser_en_n` is low, bits are captured MSB first on falling edges of `ser_clk`. In a word with bit 7 = 0, bits 6:5 select the target (01 = channel 0, 10 = channel 1, 11 = channel 2), and bits 4:0 are loaded into that channel's code. No other register changes.
- R3: A word with bit 7 = 0 and bits 6:5 = 00 loads bits 4:1 into `slice_lvl`. The channel codes do not change.
- R4: A word with bit 7 = 1 changes no register and does not count as a write for R9.
- R5: Clock edges after the eighth bit of a frame begin a new word. A 24-clock frame therefore applies three words in order.
- R6: A register changes only when the eighth bit of a word is captured. A partial word left when the frame ends is discarded.
- R7: Each falling edge of `ser_en_n` resets the bit position to the start of a word. A frame that follows one with too many or too few clocks is still decoded correctly.
- R8: `word_done` is high for exactly one system cycle for each completed word, whether or not the word is ignored.
- R9: `cal_req` is high for one system cycle after `ser_en_n` rises, if and only if that frame contained at least one word with bit 7 = 0.
- R10: Serial clock edges while `ser_en_n` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. Must run at least 4x the serial clock. |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Active-low frame select, asynchronous |
| ser_clk | input | 1 | Serial clock. Data is captured on its falling edge. |
| ser_dat | input | 1 | Serial data, MSB first |
| ch0_dly | output | 5 | Skew code of channel 0 |
| ch1_dly | output | 5 | Skew code of channel 1 |
| ch2_dly | output | 5 | Skew code of channel 2 |
| slice_lvl | output | 4 | Comparator slice-level code |
| word_done | output | 1 | One-cycle pulse for each completed 8-bit word |
| cal_req | output | 1 | One-cycle calibration request when a frame that wrote a register ends |

## Verification
Some properties are checked on every cycle. Both strobes must be single-cycle pulses. `cal_req` may only appear while the frame select is high. The bit position must clear after each frame start and must hold still while the link is idle. No register may change without a completed word, and a word with its top bit set must leave every register as it was.

Other behaviour only the bench scenarios can show. These cases are:
- every code value reaching the correct channel;
- three words streamed in one frame;
- a truncated word being dropped;
- recovery after an overlong frame;
- `cal_req` being withheld for frames that carried no valid write.

// File: rtl/skew_cfg_pkg.sv
`timescale 1ns/1ps
package skew_cfg_pkg;
  localparam int unsigned DLY_W   = 5;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned SLICE_W = 4;
  localparam int unsigned NUM_CH  = 3;
  localparam int unsigned WORD_W  = 1 + ADDR_W + DLY_W;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_TEST = 2'b00,
    SEL_CH0  = 2'b01,
    SEL_CH1  = 2'b10,
    SEL_CH2  = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/skew_sync.sv
`timescale 1ns/1ps
module skew_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/skew_ser_shift.sv
`timescale 1ns/1ps
module skew_ser_shift
  import skew_cfg_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_n_s,
  input  logic         sclk_s,
  input  logic         sdat_s,
  output logic         word_vld,
  output logic [W-1:0] word_q,
  output logic         cal_req
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);
  localparam int unsigned LEAD = W - 1;

  logic             en_d;
  logic             sclk_d;
  logic [CNT_W-1:0] bit_cnt;
  logic [W-2:0]     shreg;
  logic             pending;

  logic en_fall, en_rise, s_fall, good_word;
  assign en_fall   = en_d & ~en_n_s;
  assign en_rise   = ~en_d & en_n_s;
  assign s_fall    = sclk_d & ~sclk_s & ~en_n_s;
  assign good_word = word_vld & ~word_q[LEAD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d     <= 1'b1;
      sclk_d   <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      word_vld <= 1'b0;
      word_q   <= '0;
      pending  <= 1'b0;
      cal_req  <= 1'b0;
    end else begin
      en_d     <= en_n_s;
      sclk_d   <= sclk_s;
      word_vld <= 1'b0;
      cal_req  <= 1'b0;
      if (en_fall) begin
        bit_cnt <= '0;
        pending <= 1'b0;
      end else begin
        if (s_fall) begin
          shreg <= {shreg[W-3:0], sdat_s};
          if (bit_cnt == LAST_BIT) begin
            word_q   <= {shreg, sdat_s};
            word_vld <= 1'b1;
            bit_cnt  <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (en_rise) begin
          cal_req <= pending | good_word;
          pending <= 1'b0;
        end else if (good_word) begin
          pending <= 1'b1;
        end
      end
    end
  end

  AST_WORD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld); // R8
  AST_CAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |=> !cal_req); // R9
  AST_CAL_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> en_d); // R9
  AST_CNT_CLR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> (bit_cnt == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n_s && en_d) |=> $stable(bit_cnt)); // R10
endmodule

// File: rtl/skew_reg_bank.sv
`timescale 1ns/1ps
module skew_reg_bank
  import skew_cfg_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned DW = DLY_W,
  parameter int unsigned SW = SLICE_W,
  parameter int unsigned NC = NUM_CH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_vld,
  input  logic [W-1:0]          word_q,
  output logic [NC-1:0][DW-1:0] dly_q,
  output logic [SW-1:0]         slice_q
);
  localparam int unsigned AW = W - 1 - DW;

  logic          lead;
  logic [AW-1:0] sel;
  logic [DW-1:0] code;
  logic          accept;

  assign lead   = word_q[W-1];
  assign sel    = word_q[W-2 -: AW];
  assign code   = word_q[DW-1:0];
  assign accept = word_vld & ~lead;

  generate
    for (genvar ch = 0; ch < NC; ch++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   dly_q[ch] <= '0;
        else if (accept && (sel == AW'(ch + 1)))      dly_q[ch] <= code;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        slice_q <= '0;
    else if (accept && (sel == AW'(SEL_TEST)))         slice_q <= code[SW:1];
  end

  AST_HOLD_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> ($stable(dly_q) && $stable(slice_q))); // R6
  AST_LEAD_ONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && lead) |=> ($stable(dly_q) && $stable(slice_q))); // R4
  AST_CH0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel == AW'(SEL_CH0)) |=> (dly_q[0] == $past(code))); // R2
endmodule

// File: rtl/skew_ser_cfg.sv
`timescale 1ns/1ps
module skew_ser_cfg
  import skew_cfg_pkg::*;
#(
  parameter int unsigned DW = DLY_W,
  parameter int unsigned SW = SLICE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_en_n,
  input  logic          ser_clk,
  input  logic          ser_dat,
  output logic [DW-1:0] ch0_dly,
  output logic [DW-1:0] ch1_dly,
  output logic [DW-1:0] ch2_dly,
  output logic [SW-1:0] slice_lvl,
  output logic          word_done,
  output logic          cal_req
);
  localparam int unsigned W = 1 + ADDR_W + DW;

  logic [2:0] pins_s;
  logic       word_vld;
  logic [W-1:0] word_q;
  logic [NUM_CH-1:0][DW-1:0] dly_q;

  skew_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_en_n, ser_clk, ser_dat}),
    .q     (pins_s)
  );

  skew_ser_shift #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_n_s   (pins_s[2]),
    .sclk_s   (pins_s[1]),
    .sdat_s   (pins_s[0]),
    .word_vld (word_vld),
    .word_q   (word_q),
    .cal_req  (cal_req)
  );

  skew_reg_bank #(.W(W), .DW(DW), .SW(SW), .NC(NUM_CH)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .word_q   (word_q),
    .dly_q    (dly_q),
    .slice_q  (slice_lvl)
  );

  assign ch0_dly   = dly_q[0];
  assign ch1_dly   = dly_q[1];
  assign ch2_dly   = dly_q[2];
  assign word_done = word_vld;
endmodule

// File: tb/skew_ser_cfg_tb.sv
`timescale 1ns/1ps
module skew_ser_cfg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en_n = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic [4:0] ch0_dly, ch1_dly, ch2_dly;
  logic [3:0] slice_lvl;
  logic word_done, cal_req;

  int nchk = 0, nfail = 0;
  int wd_cnt = 0, cal_cnt = 0;
  int exp_wd = 0, exp_cal = 0;
  int exp_d[3] = '{0, 0, 0};
  int exp_s = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  skew_ser_cfg dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .ch0_dly(ch0_dly), .ch1_dly(ch1_dly), .ch2_dly(ch2_dly),
    .slice_lvl(slice_lvl), .word_done(word_done), .cal_req(cal_req)
  );

  always @(negedge clk) if (rst_n) begin
    if (word_done) wd_cnt++;
    if (cal_req)   cal_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " ch0"}, int'(ch0_dly), exp_d[0]);
    chk({req, " ch1"}, int'(ch1_dly), exp_d[1]);
    chk({req, " ch2"}, int'(ch2_dly), exp_d[2]);
    chk({req, " slice"}, int'(slice_lvl), exp_s);
    chk({req, " R8 words"}, wd_cnt, exp_wd);
    chk({req, " R9 cal"}, cal_cnt, exp_cal);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      ser_clk = 1'b1; #20;
      ser_clk = 1'b0; #20;
    end
  endtask

  task automatic frame(input logic [31:0] bits, input int n);
    ser_en_n = 1'b0; #40;
    shift_bits(bits, n);
    #40 ser_en_n = 1'b1;
    #200;
  endtask

  function automatic logic [7:0] mkw(input int sel, input int code);
    return {1'b0, 2'(sel), 5'(code)};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #23 rst_n = 1'b1;
    #100;
    check_all("R1 reset");

    // R2: every code into every channel, single-word frames
    for (int ch = 0; ch < 3; ch++) begin
      for (int c = 0; c < 32; c++) begin
        frame({24'd0, mkw(ch + 1, c)}, 8);
        exp_d[ch] = c; exp_wd++; exp_cal++;
        check_all("R2 sweep");
      end
    end

    // R3: slice sweep, low bit of word zero
    for (int v = 0; v < 16; v++) begin
      frame({24'd0, mkw(0, v * 2)}, 8);
      exp_s = v; exp_wd++; exp_cal++;
      check_all("R3 slice");
    end

    // R5: three words streamed in one frame
    frame({8'd0, mkw(1, 5), mkw(2, 17), mkw(3, 30)}, 24);
    exp_d[0] = 5; exp_d[1] = 17; exp_d[2] = 30; exp_wd += 3; exp_cal++;
    check_all("R5 stream");

    // R4: leading one ignored, no calibration request
    frame({24'd0, 8'b1_01_10101}, 8);
    exp_wd++;
    check_all("R4 lead1");

    // R4 with R9: ignored then valid word in one frame gives one request
    frame({16'd0, 8'b1_10_00001, mkw(3, 9)}, 16);
    exp_d[2] = 9; exp_wd += 2; exp_cal++;
    check_all("R4 R9 mixed");

    // R6: partial word dropped
    frame({27'd0, 5'b01011}, 5);
    check_all("R6 partial");

    // R6: one full word plus a partial tail
    frame({17'd0, mkw(2, 3), 7'b0111111}, 15);
    exp_d[1] = 3; exp_wd++; exp_cal++;
    check_all("R6 tail");

    // R7: overlong frame then clean frame
    frame({21'd0, mkw(1, 12), 3'b111}, 11);
    exp_d[0] = 12; exp_wd++; exp_cal++;
    frame({24'd0, mkw(1, 27)}, 8);
    exp_d[0] = 27; exp_wd++; exp_cal++;
    check_all("R7 recover");

    // R10: clocks while frame select high
    ser_en_n = 1'b1;
    shift_bits({24'd0, mkw(1, 1)}, 8);
    #200;
    check_all("R10 idle clocks");

    // R9: empty frame gives no request
    frame(32'd0, 0);
    check_all("R9 empty");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule